// File: doc/BRIEF.md
# ALU Status Flag Generator

This block performs the flag-producing part of an integer ALU. It takes two operands, a carry-in, an operation and an operand size (byte, halfword or word), forms the result at that width and derives the six arithmetic status flags from it: carry, parity, auxiliary carry, zero, sign and overflow. The flags are kept in a 16-bit flags word alongside three control bits (direction, interrupt enable, single step). Software-visible instructions move those three bits only through explicit set and clear pins; arithmetic never touches them.

Operations arrive on a valid/ready stream and results leave on a second valid/ready stream held in a single output register. An operation is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a stalled consumer (`out_ready` low with `out_valid` high) stops new operations. While stalled, the result and its write strobe are held unchanged. The flags word is updated on the same edge that takes the operation, when `flag_upd_en` is high. A combinational condition evaluator reads the current flags word and answers a 4-bit condition code for conditional branches.

Top module: `alu_status_flags`

## Requirements
- R1: After reset the flags word reads 0x0002, `out_valid` is low and `in_ready` is high.
- R2: Flags word layout: carry bit 0, parity bit 2, auxiliary carry bit 4, zero bit 6, sign bit 7, single step bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11; bit 1 always reads 1 and bits 3, 5 and 12 to 15 always read 0.
- R3: `op_code` 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR, 7 CMP; `op_size` 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Operand bits above the selected width are ignored and the result is zero-extended; ADC adds `carry_in`, SBB subtracts it, the other operations ignore it.
- R4: The sign flag equals the result's top bit at the selected width and the zero flag is set exactly when the result at that width is zero.
- R5: The parity flag is set when the low 8 bits of the result hold an even number of ones, for every width.
- R6: For arithmetic operations the auxiliary carry flag is set on a carry out of bit 3 (add) or a borrow into bit 3 (subtract).
- R7: For arithmetic operations the carry flag is set on a carry out of, or a borrow into, the top bit of the selected width.
- R8: For arithmetic operations the overflow flag is set when the signed result does not fit the selected width.
- R9: AND, OR and XOR clear carry and overflow, update sign, zero and parity, and leave the auxiliary carry flag unchanged.
- R10: CMP updates the flags as SUB does and presents the difference, but with `out_wr` low; every other operation gives `out_wr` high.
- R11: An operation taken with `flag_upd_en` low produces its result and leaves all six status flags unchanged.
- R12: `ctl_set[i]` and `ctl_clr[i]` (i = 0 single step, 1 interrupt enable, 2 direction) set or clear flag bit 8+i on the next edge; clear wins when both are high; these bits change by no other means.
- R13: `in_ready` equals `!out_valid || out_ready`; result and flags appear one edge after acceptance; while `out_valid` is high and `out_ready` low, `out_result` and `out_wr` hold.
- R14: `cond_true` for `cond_code` c is base(c>>1) XOR c[0], with base 0 ZF, 1 SF!=OF, 2 ZF|(SF!=OF), 3 CF, 4 CF|ZF, 5 SF, 6 OF, 7 PF; so 0 equal, 1 not equal, 2 signed less, 4 signed less-or-equal, 6 unsigned below, 8 unsigned below-or-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| carry_in | input | 1 | Carry or borrow into ADC and SBB |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand width select |
| flag_upd_en | input | 1 | Status flags follow this operation |
| ctl_set | input | 3 | Set single step, interrupt enable, direction |
| ctl_clr | input | 3 | Clear single step, interrupt enable, direction |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Result, zero-extended from the selected width |
| out_wr | output | 1 | Result is to be written back |
| flags | output | 16 | Flags word |
| cond_code | input | 4 | Condition to evaluate |
| cond_true | output | 1 | Condition holds on the current flags word |

## Verification
The result, `out_wr` and the six status flags are all due one rising edge after the edge that takes an operation, and control-bit commands land one edge after they are driven; the bench drives on the falling edge, waits for the taking edge and reads the outputs at the following falling edge. `cond_true` is combinational on the flags word, so it is read in the same half-cycle as the flags it depends on, after the operation that produced them. During the back-pressure test the outputs are read at every falling edge of the stall to confirm they are held, and the second operation's result is expected only after the edge where `out_ready` returns high.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } op_size_e;

  // Bit positions inside the 16-bit flags word.
  localparam int FB_CF = 0;
  localparam int FB_ONE = 1;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;
  localparam int FLAGS_W = 16;
  localparam int CTL_N = 3;
  localparam int CTL_BASE = FB_TF;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } status_t;

  function automatic logic op_is_logic(input logic [2:0] op);
    return op == OP_AND || op == OP_OR || op == OP_XOR;
  endfunction

endpackage

// File: rtl/flag_arith.sv
module flag_arith
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              af_prev,
  output logic [DATA_W-1:0] result,
  output status_t           st
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int W_BYTE = 8;
  localparam int W_HALF = 16;

  logic [DATA_W-1:0] mask;
  logic [IDX_W-1:0]  msb;
  logic [IDX_W-1:0]  cidx;
  logic [DATA_W-1:0] a_m, b_m, lres, ares;
  logic [DATA_W:0]   ext, cin_ext;
  logic              is_sub, is_logic;
  logic              sa, sb, sr;

  always_comb begin
    case (op_size_e'(size))
      SZ_BYTE: begin
        mask = DATA_W'({W_BYTE{1'b1}});
        msb  = IDX_W'(W_BYTE - 1);
      end
      SZ_HALF: begin
        mask = DATA_W'({W_HALF{1'b1}});
        msb  = IDX_W'(W_HALF - 1);
      end
      default: begin
        mask = '1;
        msb  = IDX_W'(DATA_W - 1);
      end
    endcase
    cidx = msb + IDX_W'(1);
  end

  always_comb begin
    a_m      = a & mask;
    b_m      = b & mask;
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    is_logic = op_is_logic(op);
    cin_ext  = (DATA_W+1)'(cin & ((op == OP_ADC) || (op == OP_SBB)));
    if (is_sub) ext = {1'b0, a_m} - {1'b0, b_m} - cin_ext;
    else        ext = {1'b0, a_m} + {1'b0, b_m} + cin_ext;
    ares = ext[DATA_W-1:0] & mask;
    case (alu_op_e'(op))
      OP_AND:  lres = a_m & b_m;
      OP_OR:   lres = a_m | b_m;
      OP_XOR:  lres = a_m ^ b_m;
      default: lres = '0;
    endcase
    result = is_logic ? lres : ares;
  end

  always_comb begin
    sa = a_m[msb];
    sb = b_m[msb];
    sr = result[msb];
    st.sf = sr;
    st.zf = (result == '0);
    st.pf = ~^result[7:0];
    if (is_logic) begin
      st.cf = 1'b0;
      st.of = 1'b0;
      st.af = af_prev;
    end else begin
      st.cf = ext[cidx];
      st.af = a_m[4] ^ b_m[4] ^ ext[4];
      if (is_sub) st.of = (sa != sb) && (sr != sa);
      else        st.of = (sa == sb) && (sr != sa);
    end
  end

endmodule

// File: rtl/flag_cond.sv
module flag_cond
  import alu_flags_pkg::*;
(
  input  logic [FLAGS_W-1:0] flags,
  input  logic [3:0]         code,
  output logic               hit
);
  logic       lt;
  logic [7:0] base;

  always_comb begin
    lt = flags[FB_SF] ^ flags[FB_OF];
    base[0] = flags[FB_ZF];
    base[1] = lt;
    base[2] = flags[FB_ZF] | lt;
    base[3] = flags[FB_CF];
    base[4] = flags[FB_CF] | flags[FB_ZF];
    base[5] = flags[FB_SF];
    base[6] = flags[FB_OF];
    base[7] = flags[FB_PF];
    hit = base[code[3:1]] ^ code[0];
  end

endmodule

// File: rtl/alu_status_flags.sv
module alu_status_flags
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              carry_in,
  input  logic [2:0]        op_code,
  input  logic [1:0]        op_size,
  input  logic              flag_upd_en,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic [15:0]       flags,
  input  logic [3:0]        cond_code,
  output logic              cond_true
);
  logic              accept;
  logic [DATA_W-1:0] calc_res;
  status_t           calc_st, stat_q;
  logic [CTL_N-1:0]  ctl_q;
  logic [FLAGS_W-1:0] flags_w;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  flag_arith #(.DATA_W(DATA_W)) i_arith (
    .a       (op_a),
    .b       (op_b),
    .cin     (carry_in),
    .op      (op_code),
    .size    (op_size),
    .af_prev (stat_q.af),
    .result  (calc_res),
    .st      (calc_st)
  );

  // Output register of the result stream.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= calc_res;
      out_wr     <= (op_code != OP_CMP);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // Status flags follow accepted operations when enabled.
  always_ff @(posedge clk) begin
    if (!rst_n)                    stat_q <= '0;
    else if (accept && flag_upd_en) stat_q <= calc_st;
  end

  // Control flags: explicit commands only, clear dominates.
  generate
    for (genvar gi = 0; gi < CTL_N; gi++) begin : g_ctl
      always_ff @(posedge clk) begin
        if (!rst_n)             ctl_q[gi] <= 1'b0;
        else if (ctl_clr[gi])   ctl_q[gi] <= 1'b0;
        else if (ctl_set[gi])   ctl_q[gi] <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    flags_w         = '0;
    flags_w[FB_ONE] = 1'b1;
    flags_w[FB_CF]  = stat_q.cf;
    flags_w[FB_PF]  = stat_q.pf;
    flags_w[FB_AF]  = stat_q.af;
    flags_w[FB_ZF]  = stat_q.zf;
    flags_w[FB_SF]  = stat_q.sf;
    flags_w[FB_OF]  = stat_q.of;
    flags_w[CTL_BASE +: CTL_N] = ctl_q;
  end
  assign flags = flags_w;

  flag_cond i_cond (
    .flags (flags_w),
    .code  (cond_code),
    .hit   (cond_true)
  );

  // R12: control bits move only under a command.
  assert_ctl_only_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[FB_DF:FB_TF]));

  // R12: a clear command always leaves its bit low.
  assert_clr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr != '0) |=> ((flags[FB_DF:FB_TF] & $past(ctl_clr)) == '0));

  // R11: status holds unless an enabled operation is taken.
  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && flag_upd_en) |=>
      $stable({flags[FB_OF], flags[FB_SF], flags[FB_ZF], flags[FB_AF], flags[FB_PF], flags[FB_CF]}));

  // R13: stalled output is held.
  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr)));

  // R9: logical operations leave carry and overflow clear.
  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flag_upd_en && op_is_logic(op_code)) |=> (!flags[FB_CF] && !flags[FB_OF]));

  // R4 and R5: zero and parity agree with the presented result.
  assert_zero_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flag_upd_en) |=>
      (flags[FB_ZF] == (out_result == '0)) && (flags[FB_PF] == ~^out_result[7:0]));

  // R10: compare never requests a write.
  assert_cmp_no_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code == OP_CMP) |=> !out_wr);

endmodule

// File: tb/test_alu_status_flags.sv
module test_alu_status_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [31:0] res;
    logic [15:0] fl;
    logic        wr;
  } vec_t;

  // Run in order: logical rows rely on the auxiliary carry left by the row above.
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0000, 16'h0057, 1'b1},
    '{3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 32'h0000_0080, 16'h0892, 1'b1},
    '{3'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, 32'h0000_00FF, 16'h0097, 1'b1},
    '{3'd2, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b0, 32'h0000_007F, 16'h0812, 1'b1},
    '{3'd0, 2'd1, 32'hABCD_12FF, 32'h0000_0001, 1'b0, 32'h0000_1300, 16'h0016, 1'b1},
    '{3'd1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 16'h0057, 1'b1},
    '{3'd3, 2'd1, 32'h0000_8000, 32'h0000_0000, 1'b1, 32'h0000_7FFF, 16'h0816, 1'b1},
    '{3'd4, 2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 32'h0000_0000, 16'h0056, 1'b1},
    '{3'd5, 2'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 32'h8000_0001, 16'h0092, 1'b1},
    '{3'd6, 2'd0, 32'h0000_000F, 32'h0000_0003, 1'b0, 32'h0000_000C, 16'h0016, 1'b1},
    '{3'd7, 2'd1, 32'h0000_0005, 32'h0000_0007, 1'b0, 32'h0000_FFFE, 16'h0093, 1'b0},
    '{3'd2, 2'd2, 32'h0000_0003, 32'h0000_0003, 1'b1, 32'h0000_0000, 16'h0046, 1'b1},
    '{3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 16'h0847, 1'b1},
    '{3'd6, 2'd0, 32'h0000_00AA, 32'h0000_0055, 1'b0, 32'h0000_00FF, 16'h0086, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  op_size = '0;
  logic        flag_upd_en = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr;
  logic [15:0] flags;
  logic [3:0]  cond_code = '0;
  logic        cond_true;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_status_flags #(.DATA_W(32)) i_alu_status_flags (
    .clk, .rst_n, .in_valid, .in_ready, .op_a, .op_b, .carry_in, .op_code,
    .op_size, .flag_upd_en, .ctl_set, .ctl_clr, .out_valid, .out_ready,
    .out_result, .out_wr, .flags, .cond_code, .cond_true
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic cin, input logic upd);
    @(negedge clk);
    op_code = op; op_size = sz; op_a = a; op_b = b; carry_in = cin;
    flag_upd_en = upd; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_cond(input logic [3:0] c, input logic exp, input string req);
    cond_code = c;
    #1;
    chk(req, 32'(cond_true), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 flags after reset", 32'(flags), 32'h0002);
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    chk("R1 in_ready after reset", 32'(in_ready), 1);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      do_op(VECS[i].op, VECS[i].sz, VECS[i].a, VECS[i].b, VECS[i].cin, 1'b1);
      chk($sformatf("R3 result row %0d", i), out_result, VECS[i].res);
      chk($sformatf("R2 R4 R5 R6 R7 R8 R9 flags row %0d", i), 32'(flags), 32'(VECS[i].fl));
      chk($sformatf("R10 write strobe row %0d", i), 32'(out_wr), 32'(VECS[i].wr));
      chk($sformatf("R13 out_valid row %0d", i), 32'(out_valid), 1);
    end

    // R14: conditions after compare 5 with 7 (16-bit)
    do_op(3'd7, 2'd1, 32'd5, 32'd7, 1'b0, 1'b1);
    chk_cond(4'd0, 1'b0, "R14 equal 5,7");
    chk_cond(4'd1, 1'b1, "R14 not equal 5,7");
    chk_cond(4'd2, 1'b1, "R14 signed less 5,7");
    chk_cond(4'd5, 1'b0, "R14 signed greater 5,7");
    chk_cond(4'd6, 1'b1, "R14 below 5,7");
    chk_cond(4'd9, 1'b0, "R14 above 5,7");
    // compare 7 with 5
    do_op(3'd7, 2'd1, 32'd7, 32'd5, 1'b0, 1'b1);
    chk_cond(4'd2, 1'b0, "R14 signed less 7,5");
    chk_cond(4'd5, 1'b1, "R14 signed greater 7,5");
    chk_cond(4'd9, 1'b1, "R14 above 7,5");
    // equal operands
    do_op(3'd7, 2'd2, 32'd5, 32'd5, 1'b0, 1'b1);
    chk_cond(4'd0, 1'b1, "R14 equal 5,5");
    chk_cond(4'd4, 1'b1, "R14 less-or-equal 5,5");
    chk_cond(4'd8, 1'b1, "R14 below-or-equal 5,5");
    chk_cond(4'd5, 1'b0, "R14 signed greater 5,5");
    // signed and unsigned disagree: 0xFF vs 0x01 at byte width
    do_op(3'd7, 2'd0, 32'hFF, 32'h01, 1'b0, 1'b1);
    chk_cond(4'd2, 1'b1, "R14 signed less FF,01");
    chk_cond(4'd9, 1'b1, "R14 above FF,01");
    chk_cond(4'd14, 1'b0, "R14 parity even FE");

    // R12: control bits
    @(negedge clk);
    ctl_set = 3'b111;
    @(negedge clk);
    ctl_set = 3'b000;
    chk("R12 set all control bits", 32'(flags[10:8]), 32'b111);
    ctl_set = 3'b001; ctl_clr = 3'b001;
    @(negedge clk);
    ctl_set = 3'b000; ctl_clr = 3'b000;
    chk("R12 clear wins over set", 32'(flags[10:8]), 32'b110);
    do_op(3'd0, 2'd0, 32'hFF, 32'h01, 1'b0, 1'b1);
    chk("R12 arithmetic keeps control bits", 32'(flags), 32'h0657);
    @(negedge clk);
    ctl_clr = 3'b111;
    @(negedge clk);
    ctl_clr = 3'b000;
    chk("R12 clear all control bits", 32'(flags), 32'h0057);

    // R11: update disabled
    do_op(3'd2, 2'd0, 32'h80, 32'h01, 1'b0, 1'b0);
    chk("R11 result still produced", out_result, 32'h7F);
    chk("R11 status unchanged", 32'(flags), 32'h0057);

    // R13: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    op_code = 3'd0; op_size = 2'd0; op_a = 32'd1; op_b = 32'd2; carry_in = 1'b0;
    flag_upd_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    op_a = 32'd3; op_b = 32'd4;
    chk("R13 first result", out_result, 32'd3);
    chk("R13 in_ready low while stalled", 32'(in_ready), 0);
    @(negedge clk);
    chk("R13 result held in stall", out_result, 32'd3);
    chk("R13 valid held in stall", 32'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    chk("R13 in_ready follows out_ready", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13 second result after release", out_result, 32'd7);
    chk("R13 valid for second result", 32'(out_valid), 1);
    @(negedge clk);
    chk("R13 output drains", 32'(out_valid), 0);

    finish_run();
  end

endmodule